// File: doc/BRIEF.md
# Five-Switch Unipolar PWM Gate Sequencer

This block drives the five power switches of a single-phase, three-level inverter. In this inverter the negative output level comes from a switched-capacitor auxiliary bus, not from a second full bridge. The block runs its own symmetric triangular carrier. Each cycle it compares the magnitude of a signed modulation sample with that carrier. The sign of the sample chooses the half-cycle. In the positive half, the leg pair (switches 4 and 5) toggles and the bridge group stays in its charging position. In the negative half, switch 5 stays on and the bridge group (switches 1 and 3 together, against switch 2) toggles. That toggling produces the negative level and also recharges the auxiliary capacitor.

Each complementary pair passes through its own dead-band stage. When a pair changes side, both of its gates stay off for a programmable number of clock cycles. A change of sign in the modulation sample takes effect only at a carrier valley, so a half-cycle change never cuts a pulse short. When reset is asserted or enable is low, every gate is off.

Top module: `spwm5_gate_gen`

## Requirements
- R1: The carrier counts 0,1,…,P,P−1,…,1,0,1,… where P is `car_peak`, so it repeats every 2·P clocks. It is held at 0 while disabled, and it stays at 0 when P is 0.
- R2: The half-cycle is taken from the sign of `mod_in` (zero counts as positive) only in a clock where the carrier is at 0. In all other clocks the polarity latched at the last valley applies.
- R3: In the positive half, switches 1 and 3 are on and switch 2 is off. Switch 4 is on while |mod_in| > carrier, and switch 5 is on otherwise.
- R4: In the negative half, switch 5 is on and switch 4 is off. Switch 2 is on while |mod_in| > carrier, and switches 1 and 3 are on otherwise.
- R5: When a pair (4/5, or 1+3/2) is asked to change side, both of its gates stay off for exactly `dead_cyc` clocks and then the new side turns on. With `dead_cyc` = 0 there is no gap.
- R6: After a clock edge at which reset is high or enable is low, all gates are off. After enable returns, each pair stays off for `dead_cyc` clocks before it turns on.
- R7: `level_o` reports the applied level: 2'b01 when switches 1, 3 and 4 are on; 2'b10 when switches 1, 3 and 5 are on; 2'b11 when switches 2 and 5 are on; 2'b00 in every other case (off or in a dead gap).
- R8: `gate_o` bit i drives switch i+1. Bits 0 and 2 are always equal. Bit 3 and bit 4 are never on together, and bit 1 is never on together with bit 0.
- R9: A magnitude larger than the peak, including the most negative code, keeps the half-cycle's active level on without any toggling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low forces all gates off |
| mod_in | input | CW+1 | Signed two's-complement modulation sample |
| car_peak | input | CW | Carrier peak count P |
| dead_cyc | input | DW | Dead time in clock cycles |
| gate_o | output | 5 | Gate commands, bit i = switch i+1 |
| level_o | output | 2 | Applied output level code |

## Verification
On every cycle, the bound checker confirms four things: gates go off one clock after reset or disable; a gate turns on only after its partner was off whenever a dead time is set; the effective polarity stays frozen while the carrier is away from its valley; and the level code is idle while disabled. Other behaviours need a reference model that is driven through whole carrier periods: the exact 2·P carrier period, the duty pattern for each magnitude, the exact length of each dead gap, the delay after re-enable, and saturation at full or most-negative modulation. The bench's scenarios cover these.

// File: rtl/spwm5_pkg.sv
package spwm5_pkg;

    localparam int NUM_SW    = 5;
    localparam int NUM_PAIRS = 2;
    localparam int PAIR_LEG    = 0;   // switch 4 (hi) against switch 5 (lo)
    localparam int PAIR_BRIDGE = 1;   // switches 1+3 (hi) against switch 2 (lo)

    typedef enum logic [1:0] {
        LVL_IDLE = 2'b00,
        LVL_POS  = 2'b01,
        LVL_ZERO = 2'b10,
        LVL_NEG  = 2'b11
    } level_e;

    typedef struct packed {
        logic s5;
        logic s4;
        logic s3;
        logic s2;
        logic s1;
    } gates_t;

    // Side each pair should take for a requested level.
    function automatic logic [NUM_PAIRS-1:0] level_want(level_e lvl);
        logic [NUM_PAIRS-1:0] w;
        w[PAIR_LEG]    = (lvl == LVL_POS);
        w[PAIR_BRIDGE] = (lvl != LVL_NEG);
        return w;
    endfunction

    function automatic gates_t pairs_to_gates(logic [NUM_PAIRS-1:0] hi,
                                              logic [NUM_PAIRS-1:0] lo);
        gates_t g;
        g.s1 = hi[PAIR_BRIDGE];
        g.s3 = hi[PAIR_BRIDGE];
        g.s2 = lo[PAIR_BRIDGE];
        g.s4 = hi[PAIR_LEG];
        g.s5 = lo[PAIR_LEG];
        return g;
    endfunction

    function automatic level_e gates_to_level(gates_t g);
        level_e l;
        case (g)
            5'b01101: l = LVL_POS;
            5'b10101: l = LVL_ZERO;
            5'b10010: l = LVL_NEG;
            default:  l = LVL_IDLE;
        endcase
        return l;
    endfunction

endpackage

// File: rtl/spwm5_carrier.sv
module spwm5_carrier #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [CW-1:0] peak,
    output logic [CW-1:0] cnt,
    output logic          valley
);
    logic rising;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt    <= '0;
            rising <= 1'b1;
        end else if (rising) begin
            if (cnt >= peak) begin
                if (cnt != '0) begin
                    cnt    <= cnt - 1'b1;
                    rising <= 1'b0;
                end
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else begin
            if (cnt == '0) begin
                if (peak != '0) begin
                    cnt    <= {{(CW-1){1'b0}}, 1'b1};
                    rising <= 1'b1;
                end
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    assign valley = (cnt == '0);

endmodule

// File: rtl/spwm5_mod_select.sv
module spwm5_mod_select
    import spwm5_pkg::*;
#(
    parameter int CW = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [CW:0]   mod_in,
    input  logic [CW-1:0]        car_cnt,
    input  logic                 car_valley,
    output logic                 pol_eff,
    output level_e               level_req
);
    logic        pos_q;
    logic        sign_pos;
    logic [CW:0] mag;
    logic        active;

    assign sign_pos = !mod_in[CW];
    assign mag      = mod_in[CW] ? (~mod_in + 1'b1) : mod_in;
    assign active   = mag > {1'b0, car_cnt};

    // Polarity is sampled only at the carrier valley.
    always_ff @(posedge clk) begin
        if (rst)             pos_q <= 1'b1;
        else if (car_valley) pos_q <= sign_pos;
    end

    assign pol_eff = car_valley ? sign_pos : pos_q;

    always_comb begin
        if (!active)      level_req = LVL_ZERO;
        else if (pol_eff) level_req = LVL_POS;
        else              level_req = LVL_NEG;
    end

endmodule

// File: rtl/spwm5_deadband.sv
module spwm5_deadband #(
    parameter int DW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          run,
    input  logic          want,
    input  logic [DW-1:0] dead,
    output logic          on_hi,
    output logic          on_lo
);
    logic          side_q;
    logic [DW-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            side_q <= want;
            gap_q  <= dead;
        end else if (want != side_q) begin
            side_q <= want;
            gap_q  <= dead;
        end else if (run && gap_q != '0) begin
            gap_q <= gap_q - 1'b1;
        end
    end

    assign on_hi = run && (gap_q == '0) &&  side_q;
    assign on_lo = run && (gap_q == '0) && !side_q;

endmodule

// File: rtl/spwm5_gate_gen.sv
module spwm5_gate_gen
    import spwm5_pkg::*;
#(
    parameter int CW = 10,
    parameter int DW = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic signed [CW:0]   mod_in,
    input  logic [CW-1:0]        car_peak,
    input  logic [DW-1:0]        dead_cyc,
    output logic [NUM_SW-1:0]    gate_o,
    output logic [1:0]           level_o
);
    logic [CW-1:0]        car_cnt;
    logic                 car_valley;
    logic                 pol_eff;
    level_e               level_req;
    logic [NUM_PAIRS-1:0] want;
    logic [NUM_PAIRS-1:0] hi;
    logic [NUM_PAIRS-1:0] lo;
    logic                 run_q;
    gates_t               gates;

    always_ff @(posedge clk) begin
        if (rst) run_q <= 1'b0;
        else     run_q <= en;
    end

    spwm5_carrier #(.CW(CW)) u_carrier (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .peak   (car_peak),
        .cnt    (car_cnt),
        .valley (car_valley)
    );

    spwm5_mod_select #(.CW(CW)) u_select (
        .clk        (clk),
        .rst        (rst),
        .mod_in     (mod_in),
        .car_cnt    (car_cnt),
        .car_valley (car_valley),
        .pol_eff    (pol_eff),
        .level_req  (level_req)
    );

    assign want = level_want(level_req);

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        spwm5_deadband #(.DW(DW)) u_db (
            .clk   (clk),
            .rst   (rst),
            .en    (en),
            .run   (run_q),
            .want  (want[p]),
            .dead  (dead_cyc),
            .on_hi (hi[p]),
            .on_lo (lo[p])
        );
    end

    assign gates   = pairs_to_gates(hi, lo);
    assign gate_o  = gates;
    assign level_o = gates_to_level(gates);

endmodule

// File: rtl/spwm5_gate_gen_chk.sv
module spwm5_gate_gen_chk #(
    parameter int CW = 10,
    parameter int DW = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          en,
    input logic [DW-1:0] dead_cyc,
    input logic [4:0]    gate_o,
    input logic [1:0]    level_o,
    input logic [CW-1:0] car_cnt,
    input logic          pol_eff
);
    AST_RESET_OFF: assert property (@(posedge clk) rst |=> (gate_o == 5'b0)); // R6
    AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (rst) !en |=> (gate_o == 5'b0)); // R6
    AST_IDLE_CODE: assert property (@(posedge clk) disable iff (rst) !en |=> (level_o == 2'b00)); // R7
    AST_LEG_GAP: assert property (@(posedge clk) disable iff (rst) ($rose(gate_o[3]) && $past(dead_cyc) != '0) |-> !$past(gate_o[4])); // R5
    AST_BRIDGE_GAP: assert property (@(posedge clk) disable iff (rst) ($rose(gate_o[1]) && $past(dead_cyc) != '0) |-> !$past(gate_o[0])); // R5
    AST_POLARITY_HOLD: assert property (@(posedge clk) disable iff (rst) (car_cnt != '0) |-> (pol_eff == $past(pol_eff))); // R2
endmodule

bind spwm5_gate_gen spwm5_gate_gen_chk #(.CW(CW), .DW(DW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .dead_cyc (dead_cyc),
    .gate_o   (gate_o),
    .level_o  (level_o),
    .car_cnt  (car_cnt),
    .pol_eff  (pol_eff)
);

// File: tb/test_spwm5_gate_gen.sv
module test_spwm5_gate_gen;
    localparam int CW = 10;
    localparam int DW = 6;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                en  = 1'b0;
    logic signed [CW:0]  mod_in = '0;
    logic [CW-1:0]       car_peak = 10'd8;
    logic [DW-1:0]       dead_cyc = '0;
    logic [4:0]          gate_o;
    logic [1:0]          level_o;

    int vectors = 0;
    int fails   = 0;
    int cyc     = 0;
    int last_rise = -1;
    int rise_gap  = 0;
    int s4_on = 0, s5_on = 0, s2_on = 0;
    logic prev_s4 = 1'b0;

    always #10 clk = ~clk;

    spwm5_gate_gen #(.CW(CW), .DW(DW)) i_spwm5_gate_gen (
        .clk(clk), .rst(rst), .en(en), .mod_in(mod_in),
        .car_peak(car_peak), .dead_cyc(dead_cyc),
        .gate_o(gate_o), .level_o(level_o)
    );

    // Behavioural reference state
    int m_car = 0, m_up = 1, m_pos = 1, m_run = 0;
    int m_side [2];
    int m_cnt  [2];

    function automatic int mag_of(int v);
        return (v < 0) ? -v : v;
    endfunction

    always @(posedge clk) begin : ref_model
        int o_car, o_up, o_pos, o_run, mv, pk, pol, lvl;
        int w [2];
        o_car = m_car; o_up = m_up; o_pos = m_pos; o_run = m_run;
        mv = mod_in; pk = car_peak;
        pol = (o_car == 0) ? (mv >= 0) : o_pos;
        if (mag_of(mv) > o_car) lvl = pol ? 1 : 3;
        else                    lvl = 2;
        w[0] = (lvl == 1);
        w[1] = (lvl != 3);
        if (rst || !en) begin
            m_car = 0; m_up = 1;
        end else if (o_up != 0) begin
            if (o_car >= pk) begin
                if (o_car != 0) begin m_car = o_car - 1; m_up = 0; end
            end else m_car = o_car + 1;
        end else begin
            if (o_car == 0) begin
                if (pk != 0) begin m_car = 1; m_up = 1; end
            end else m_car = o_car - 1;
        end
        if (rst) m_pos = 1;
        else if (o_car == 0) m_pos = (mv >= 0);
        for (int p = 0; p < 2; p++) begin
            if (rst || !en || w[p] != m_side[p]) begin
                m_side[p] = w[p];
                m_cnt[p]  = dead_cyc;
            end else if (o_run != 0 && m_cnt[p] > 0) begin
                m_cnt[p] = m_cnt[p] - 1;
            end
        end
        m_run = rst ? 0 : int'(en);
    end

    function automatic logic [4:0] exp_gates();
        logic [4:0] g = '0;
        if (m_run != 0 && m_cnt[0] == 0) begin
            if (m_side[0] != 0) g[3] = 1'b1; else g[4] = 1'b1;
        end
        if (m_run != 0 && m_cnt[1] == 0) begin
            if (m_side[1] != 0) begin g[0] = 1'b1; g[2] = 1'b1; end
            else g[1] = 1'b1;
        end
        return g;
    endfunction

    function automatic logic [1:0] exp_level(logic [4:0] g);
        case (g)
            5'b01101: return 2'b01;
            5'b10101: return 2'b10;
            5'b10010: return 2'b11;
            default:  return 2'b00;
        endcase
    endfunction

    task automatic check(logic ok, string req, string what, int act, int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    task automatic step(int n, string req);
        for (int i = 0; i < n; i++) begin
            logic [4:0] eg;
            @(negedge clk);
            cyc++;
            eg = exp_gates();
            check(gate_o === eg, req, "gates", int'(gate_o), int'(eg));
            check(level_o === exp_level(eg), "R7", "level code", int'(level_o), int'(exp_level(eg)));
            check(gate_o[0] === gate_o[2] && !(gate_o[3] && gate_o[4]) && !(gate_o[1] && gate_o[0]),
                  "R8", "pair exclusion", int'(gate_o), int'(eg));
            if (gate_o[3] && !prev_s4) begin
                if (last_rise >= 0) rise_gap = cyc - last_rise;
                last_rise = cyc;
            end
            prev_s4 = gate_o[3];
            if (gate_o[3]) s4_on++;
            if (gate_o[4]) s5_on++;
            if (gate_o[1]) s2_on++;
        end
    endtask

    task automatic clear_counts();
        s4_on = 0; s5_on = 0; s2_on = 0; last_rise = -1; rise_gap = 0;
    endtask

    initial begin : watchdog
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog expired (all requirements)");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin : stimulus
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(gate_o === 5'b0, "R6", "gates in reset", int'(gate_o), 0);
        check(level_o === 2'b00, "R7", "level in reset", int'(level_o), 0);

        // Positive half, no dead time, peak 8
        rst = 1'b0; en = 1'b1; car_peak = 10'd8; dead_cyc = '0; mod_in = 11'sd3;
        clear_counts();
        step(50, "R3");
        check(rise_gap == 16, "R1", "carrier period peak 8", rise_gap, 16);

        // Peak change
        car_peak = 10'd5;
        step(12, "R1");
        clear_counts();
        step(30, "R1");
        check(rise_gap == 10, "R1", "carrier period peak 5", rise_gap, 10);

        // Negative half
        mod_in = -11'sd3;
        step(20, "R2");
        clear_counts();
        step(30, "R4");
        check(s4_on == 0, "R4", "switch 4 on cycles in negative half", s4_on, 0);
        check(s2_on > 0, "R4", "switch 2 active in negative half", s2_on, 1);

        // Zero modulation
        mod_in = '0;
        step(20, "R3");
        check(level_o === 2'b10, "R7", "zero level code", int'(level_o), 2);

        // Dead time in both halves
        dead_cyc = 6'd2; mod_in = 11'sd3;
        step(40, "R5");
        mod_in = -11'sd4;
        step(40, "R5");

        // Full modulation
        mod_in = 11'sd20;
        step(30, "R9");
        clear_counts();
        step(20, "R9");
        check(s4_on == 20 && s5_on == 0, "R9", "switch 4 held at full scale", s4_on, 20);
        mod_in = -11'sd1024;
        step(30, "R9");
        clear_counts();
        step(20, "R9");
        check(s2_on == 20, "R9", "switch 2 held at most negative", s2_on, 20);

        // Disable and re-enable
        en = 1'b0;
        step(1, "R6");
        check(gate_o === 5'b0, "R6", "gates after disable", int'(gate_o), 0);
        step(4, "R6");
        dead_cyc = 6'd3; mod_in = 11'sd20; en = 1'b1;
        clear_counts();
        step(3, "R6");
        check(s4_on == 0, "R6", "gap after re-enable", s4_on, 0);
        step(1, "R6");
        check(gate_o[3] === 1'b1, "R6", "switch 4 after re-enable gap", int'(gate_o[3]), 1);

        // Reset mid-run
        mod_in = 11'sd3;
        step(10, "R5");
        rst = 1'b1;
        step(1, "R6");
        check(gate_o === 5'b0, "R6", "gates after reset", int'(gate_o), 0);
        step(2, "R6");
        rst = 1'b0;
        step(30, "R3");

        // Peak zero holds carrier at valley
        dead_cyc = '0; car_peak = '0; mod_in = 11'sd1;
        step(6, "R1");
        clear_counts();
        step(10, "R1");
        check(s4_on == 10, "R1", "flat carrier keeps switch 4 on", s4_on, 10);

        // Sign change in the middle of a period
        car_peak = 10'd8; mod_in = 11'sd2;
        step(23, "R3");
        mod_in = -11'sd5;
        step(40, "R2");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule